// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Run Mask

This block gathers up to sixteen interrupt sources that are not tied to the system clock and passes them to a processor core. Each source first goes through a multi-stage synchroniser. A rising edge on the synchronised level then sets a pending bit. The core sees one request line and a four-bit vector. The vector is simply the number of the line being presented. When several lines are pending, the lowest-numbered one wins. Once presented, the vector stays fixed until the core acknowledges it. The acknowledge comes back on a small port: a valid strobe plus the vector being accepted.

Two masks act independently on the pending bits. The enable mask decides which pending lines may drive the request. The run mask decides which lines produce a single-cycle wake pulse when their pending bit becomes set. The wake pulse releases a halted core, even if that line is kept off the request path. A compact register port gives read access to both masks and the pending bits. Software can also set pending bits through this port, which is useful for tests.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the request, the wake output, both masks and all pending bits read as zero.
- R2: A low-to-high change on a source that is held for at least the synchroniser depth sets that line's pending bit. A level that stays high does not set the bit again once it has been cleared.
- R3: Among lines that are pending and enabled, the request presents the lowest-numbered line (line 0 is most urgent).
- R4: The vector equals the presented line number. While the request is high, the vector does not change until a matching acknowledge, even if a more urgent line becomes pending.
- R5: A pending line whose enable bit is 0 does not raise the request but stays pending. Setting its enable bit later raises the request for it.
- R6: Clearing the enable bit of the line being presented withdraws the request on the following cycle. The pending bit is kept.
- R7: The wake output pulses high for exactly one cycle, one clock after a pending bit with its run bit set goes from 0 to 1. This does not depend on the enable mask. Lines whose run bit is 0 never pulse it.
- R8: An acknowledge clears the pending bit of the line given by its vector. If that line is not the one presented, the request and vector stay as they are.
- R9: Register address 0 holds the enable mask and address 1 holds the run mask; both are read/write with bit n for line n. Address 2 reads the pending bits, and a write there sets every bit written as 1 and leaves bits written as 0 unchanged. Address 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_LINES | Interrupt sources, not synchronised to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Register read data, combinational from reg_addr |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Line number being presented |
| core_wake | output | 1 | One-cycle pulse that releases a halted core |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_vec | input | 4 | Vector being acknowledged |

## Verification
Three lines arrive together, and the bench acknowledges them one at a time. A design with reversed priority, or one that picks a vector before the acknowledge has cleared, would give the wrong order. A more urgent line arrives while another is being presented, and a stray acknowledge for a non-presented line is sent. A design that re-arbitrates during a request would change the vector, and a design that drops the request on any acknowledge would lose the presented line. The bench clears the enable bit of the presented line and counts the cycles until the request drops. It also holds a source level high after an acknowledge, to catch a level-sensitive latch that refires. The wake pulse is timed to the cycle, for both source edges and software sets, with the enable mask off. This catches a wake path gated by the wrong mask, one that lasts longer than one cycle, or one that fires for lines whose run bit is clear.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int IRQ_MAX = 16;
    localparam int IRQ_VW  = 4;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_RUN    = 2'd1,
        RA_PEND   = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              hit;
        logic [IRQ_VW-1:0] vec;
    } irq_pick_t;

    typedef struct packed {
        logic              valid;
        logic [IRQ_VW-1:0] vec;
    } irq_ack_t;

    function automatic logic [IRQ_MAX-1:0] vec_onehot(input logic [IRQ_VW-1:0] v);
        logic [IRQ_MAX-1:0] r;
        r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-1:0], async_in[i]};
        end
        assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import prio_irq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] pend,
    output logic [N-1:0] en_q,
    output logic [N-1:0] run_q,
    output logic [N-1:0] sw_set,
    output logic [N-1:0] rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            run_q <= '0;
        end else if (we) begin
            if (sel == RA_ENABLE) en_q  <= wdata;
            if (sel == RA_RUN)    run_q <= wdata;
        end
    end

    assign sw_set = (we && sel == RA_PEND) ? wdata : '0;

    always_comb begin
        unique case (sel)
            RA_ENABLE: rdata = en_q;
            RA_RUN:    rdata = run_q;
            RA_PEND:   rdata = pend;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import prio_irq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] run,
    input  irq_ack_t     ack,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] pend_avail,
    output logic         wake_q
);
    logic [IRQ_MAX-1:0] ack_oh;
    logic [N-1:0]       clr;
    logic [N-1:0]       pend_d;
    logic [N-1:0]       fresh;

    assign ack_oh     = vec_onehot(ack.vec);
    assign clr        = (ack.valid && int'(ack.vec) < N) ? ack_oh[N-1:0] : '0;
    assign pend_avail = pend_q & ~clr;
    assign pend_d     = pend_avail | rise | sw_set;
    assign fresh      = pend_d & ~pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            wake_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            wake_q <= |(fresh & run);
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import prio_irq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      cand,
    input  logic [N-1:0]      en,
    input  irq_ack_t          ack,
    output logic              req_q,
    output logic [IRQ_VW-1:0] vec_q
);
    irq_pick_t          pick;
    logic [IRQ_MAX-1:0] en_x;
    logic               done;

    assign en_x = IRQ_MAX'(en);

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.hit = 1'b1;
                pick.vec = IRQ_VW'(i);
            end
        end
    end

    assign done = (ack.valid && ack.vec == vec_q) || !en_x[vec_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            vec_q <= '0;
        end else if (req_q) begin
            if (done) req_q <= 1'b0;
        end else if (pick.hit) begin
            req_q <= 1'b1;
            vec_q <= pick.vec;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_LINES     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_src,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [N_LINES-1:0] reg_wdata,
    output logic [N_LINES-1:0] reg_rdata,
    output logic               irq_req,
    output logic [IRQ_VW-1:0]  irq_vec,
    output logic               core_wake,
    input  logic               ack_valid,
    input  logic [IRQ_VW-1:0]  ack_vec
);
    irq_ack_t           ack_s;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] en_q;
    logic [N_LINES-1:0] run_q;
    logic [N_LINES-1:0] sw_set;
    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] pend_avail;

    assign ack_s = '{valid: ack_valid, vec: ack_vec};

    irq_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .async_in(irq_src), .rise(rise)
    );

    irq_regs #(.N(N_LINES)) i_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .pend(pend_q), .en_q(en_q), .run_q(run_q), .sw_set(sw_set), .rdata(reg_rdata)
    );

    irq_pend_bank #(.N(N_LINES)) i_pend (
        .clk(clk), .rst(rst), .rise(rise), .sw_set(sw_set), .run(run_q),
        .ack(ack_s), .pend_q(pend_q), .pend_avail(pend_avail), .wake_q(core_wake)
    );

    irq_prio_sel #(.N(N_LINES)) i_sel (
        .clk(clk), .rst(rst), .cand(pend_avail & en_q), .en(en_q),
        .ack(ack_s), .req_q(irq_req), .vec_q(irq_vec)
    );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int N = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic [IRQ_VW-1:0] irq_vec,
    input logic              core_wake,
    input logic              ack_valid,
    input logic [IRQ_VW-1:0] ack_vec,
    input logic [N-1:0]      en_mask,
    input logic [N-1:0]      pend
);
    logic [IRQ_MAX-1:0] pend_x, en_x, ack_x, cand_x, low_x;
    logic               rst_q = 1'b0;

    assign pend_x = IRQ_MAX'(pend);
    assign en_x   = IRQ_MAX'(en_mask);
    assign ack_x  = ack_valid ? vec_onehot(ack_vec) : '0;
    assign cand_x = pend_x & en_x & ~ack_x;
    assign low_x  = vec_onehot(irq_vec) - 1'b1;

    always @(posedge clk) begin
        if (rst_q)
            AST_RESET_QUIET: assert (!irq_req && !core_wake && pend == '0); // R1
        rst_q <= rst;
    end

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        irq_req && !(ack_valid && ack_vec == irq_vec) |=> $stable(irq_vec)); // R4

    AST_PRIO_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> (($past(cand_x) & low_x) == '0)); // R3

    AST_REQ_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> pend_x[irq_vec]); // R8

    AST_REQ_WITHDRAW: assert property (@(posedge clk) disable iff (rst)
        irq_req && !en_x[irq_vec] |=> !irq_req); // R6

    AST_WAKE_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
        core_wake |-> pend != '0); // R7
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N(N_LINES)) i_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
    .core_wake(core_wake), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .en_mask(en_q), .pend(pend_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_src = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic        core_wake;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_vec = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int exp_q[$];
    logic req_prev = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .irq_src(irq_src), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .core_wake(core_wake),
        .ack_valid(ack_valid), .ack_vec(ack_vec)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // called just after a falling edge
    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        irq_src = irq_src | m;
        repeat (4) @(negedge clk);
        irq_src = irq_src & ~m;
    endtask

    task automatic ack(input logic [3:0] v);
        @(negedge clk);
        ack_valid = 1'b1; ack_vec = v;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20 && !irq_req; i++) @(negedge clk);
    endtask

    // scoreboard monitor: each new request is compared with the next expected vector
    always @(negedge clk) begin
        if (rst) begin
            req_prev <= 1'b0;
        end else begin
            if (irq_req && !req_prev) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected request", {28'd0, irq_vec}, 32'hffff_ffff);
                end else begin
                    check("R3/R4 presented vector", {28'd0, irq_vec}, exp_q.pop_front());
                end
            end
            req_prev <= irq_req;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 req", irq_req, 0);
        check("R1 wake", core_wake, 0);
        rd(2'd0, d); check("R1 enable mask", d, 0);
        rd(2'd1, d); check("R1 run mask", d, 0);
        rd(2'd2, d); check("R1 pending", d, 0);

        // R2 edge sets pending; R5 disabled line gives no request
        @(negedge clk);
        irq_src[5] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(2'd2, d); check("R2 pending after edge", d, 16'h0020);
        check("R5 no request while disabled", irq_req, 0);
        check("R7 no wake with run clear", core_wake, 0);

        // R5 enabling later raises request
        exp_q.push_back(5);
        wr(2'd0, 16'h0020);
        wait_req();
        check("R5 request after enable", irq_req, 1);
        repeat (3) @(negedge clk);
        check("R4 vector held", {irq_req, irq_vec}, {1'b1, 4'd5});

        // R2 held level does not re-set after ack
        ack(4'd5);
        repeat (3) @(negedge clk);
        rd(2'd2, d); check("R2 level does not refire", d, 0);
        check("R8 request dropped after ack", irq_req, 0);
        irq_src[5] = 1'b0;

        // R3 priority among simultaneous lines
        wr(2'd0, 16'hffff);
        exp_q.push_back(3); exp_q.push_back(9); exp_q.push_back(12);
        pulse(16'h1208);
        for (int k = 0; k < 3; k++) begin
            wait_req();
            ack(irq_vec);
        end
        repeat (2) @(negedge clk);
        rd(2'd2, d); check("R8 all cleared", d, 0);

        // R4 hold against more urgent arrival, R8 mismatched ack
        exp_q.push_back(7);
        pulse(16'h0080);
        wait_req();
        pulse(16'h0002);
        check("R4 vector kept on urgent arrival", {irq_req, irq_vec}, {1'b1, 4'd7});
        ack(4'd1);
        repeat (2) @(negedge clk);
        rd(2'd2, d); check("R8 mismatched ack clears its line", d, 16'h0080);
        check("R8 request kept", {irq_req, irq_vec}, {1'b1, 4'd7});
        ack(4'd7);
        repeat (2) @(negedge clk);
        check("R8 request gone", irq_req, 0);

        // R6 withdraw on enable clear
        exp_q.push_back(4);
        pulse(16'h0010);
        wait_req();
        wr(2'd0, 16'hffef);
        @(negedge clk);
        check("R6 request withdrawn", irq_req, 0);
        rd(2'd2, d); check("R6 pending kept", d, 16'h0010);
        exp_q.push_back(4);
        wr(2'd0, 16'hffff);
        wait_req();
        ack(4'd4);
        repeat (2) @(negedge clk);

        // R7 wake pulse independent of enable
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0040);
        @(negedge clk);
        irq_src[6] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 wake pulse", core_wake, 1);
        @(negedge clk);
        check("R7 wake single cycle", core_wake, 0);
        check("R7 no request with enable clear", irq_req, 0);
        irq_src[6] = 1'b0;
        @(negedge clk);
        irq_src[8] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 no wake for run-clear line", core_wake, 0);
        irq_src[8] = 1'b0;
        ack(4'd6);
        ack(4'd8);
        @(negedge clk);
        rd(2'd2, d); check("R8 idle acks clear", d, 0);

        // R9 register port
        wr(2'd2, 16'h0011);
        rd(2'd2, d); check("R9 software set", d, 16'h0011);
        wr(2'd2, 16'h0000);
        rd(2'd2, d); check("R9 zero write no effect", d, 16'h0011);
        wr(2'd3, 16'hffff);
        rd(2'd3, d); check("R9 reserved reads zero", d, 0);
        rd(2'd0, d); check("R9 enable untouched", d, 0);
        rd(2'd1, d); check("R9 run untouched", d, 16'h0040);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0040;
        @(negedge clk);
        reg_we = 1'b0;
        check("R9 software set wakes", core_wake, 1);
        exp_q.push_back(4);
        wr(2'd0, 16'h0010);
        wait_req();
        ack(4'd4);
        ack(4'd0);
        ack(4'd6);
        @(negedge clk);
        rd(2'd2, d); check("R9 pending cleared", d, 0);

        check("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule